// File: doc/BRIEF.md
# Modulo Interval Timer with Power-of-Two Prescaler

This block is an up-counting interval timer on a small synchronous register bus. Two values bound its count: a start value and a modulo (terminal) value, both 16 bits. While enabled, the counter advances once every 2^p module clocks, where p is a 3-bit prescaler setting. When the counter has reached the terminal value, its next advance reloads the start value. That reload sets a sticky overflow flag, and the flag can drive a level interrupt line.

Software stops the timer through a clock-select field and then programs the start and terminal values. A write of any data to the count register reloads the counter from the start value. The start and terminal registers are double-buffered. A write made while the timer runs goes to a holding copy only, and the counting logic picks it up once the timer is stopped. A period of N prescaled ticks therefore needs a terminal value of start+N-1. To acknowledge the overflow flag, software reads the control register and then writes the flag bit back as 0.

Top module: `mod_timer`

## Requirements
- R1: After reset the count, control and start registers read 0, the terminal register reads 0xFFFF, and irq is 0.
- R2: The counter advances only when the clock-select field (control bits [4:3]) is 1. The values 0, 2 and 3 hold the count unchanged.
- R3: With prescaler p (control bits [2:0]), the counter advances at every 2^p-th clock edge after the edge that wrote clock-select to 1. So the first advance comes 2^p cycles after the enabling write.
- R4: An advance from the terminal value loads the start value. An advance from any other value adds one.
- R5: The overflow flag (control bit 7) is set by, and only by, an advance from the terminal value to the start value.
- R6: Writing any data to the count register (offset 0x04) loads the counter with the active start value. This load takes priority over a same-cycle advance, and it does not set the flag.
- R7: Writes to the terminal (0x08) or start (0x0C) register update a holding copy that reads back at once. The copy reaches the counting logic only while clock-select is not 1. A write made while stopped takes effect on the same edge.
- R8: A control write (offset 0x00) with bit 7 at 0 clears the flag only if a control read has returned the flag as 1 since the last control write. Writing bit 7 as 1 never changes the flag, and a same-cycle overflow keeps the flag set.
- R9: irq equals the overflow flag ANDed with the interrupt enable (control bit 6).
- R10: The read data appears on rdata in the cycle after rd_en. The control register reads {flag[7], enable[6], 0[5], clock-select[4:3], prescaler[2:0]}, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset; bits [3:2] select the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions take for granted that the bus asserts at most one strobe per cycle and that the address selects one of the four word offsets. They also assume that software stops the timer before it relies on new start or terminal values. The stimulus keeps to this. It drives one bus operation per cycle, always on a word offset, and it reprograms the bounds only with clock-select at 0, except in the one test that writes the terminal value mid-run on purpose to show that the running copy holds. Each scenario starts from a stopped, reloaded counter, so the expected count follows from the number of edges between the start and stop writes.

// File: rtl/mod_timer_pkg.sv
package mod_timer_pkg;

  localparam int unsigned PS_W      = 3;
  localparam int unsigned CLKSEL_W  = 2;
  localparam int unsigned PS_LSB    = 0;
  localparam int unsigned CLKSEL_LSB = 3;
  localparam int unsigned IE_BIT    = 6;
  localparam int unsigned OF_BIT    = 7;
  localparam int unsigned CTRL_W    = 8;

  localparam logic [CLKSEL_W-1:0] CLKSEL_RUN = 2'd1;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_MODULO = 2'd2,
    SEL_START  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/mt_dbuf.sv
module mt_dbuf #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         commit,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q
);

  logic [W-1:0] buf_d;
  logic [W-1:0] act_d;

  always_comb begin
    buf_d = buf_q;
    if (wr) buf_d = wdata;
    act_d = act_q;
    if (commit) act_d = buf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= RST_VAL;
      act_q <= RST_VAL;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
    end
  end

  // R7: the running copy is frozen while the counter is clocked
  p_active_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_q));

  // R7: while stopped the running copy tracks the holding copy
  p_active_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act_q == buf_q));

endmodule

// File: rtl/mt_prescaler.sv
module mt_prescaler
  import mod_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);

  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask  = ~({DIV_W{1'b1}} << ps);
    tick  = run && ((div_q & mask) == mask);
    div_d = run ? div_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R3: with a divider above one, no tick in the first running cycle
  p_first_tick_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run) && (ps != '0)) |-> !tick);

  // R3: undivided, every running cycle ticks
  p_undivided_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (ps == '0)) |-> tick);

endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] mod_val,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf
);

  logic [CNT_W-1:0] cnt_d;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == mod_val);
    ovf    = tick && at_top && !load;
    cnt_d  = cnt_q;
    if (load)        cnt_d = start_val;
    else if (tick)   cnt_d = at_top ? start_val : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: without a tick or a load the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));

  // R4: advancing from the terminal value reloads the start value
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && (cnt_q == mod_val)) |=> (cnt_q == $past(start_val)));

  // R4: advancing below the terminal value adds one
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && (cnt_q != mod_val)) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R6: a count write reloads the start value regardless of tick
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(start_val)));

endmodule

// File: rtl/mt_regs.sv
module mt_regs
  import mod_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ovf,
  output logic [PS_W-1:0]   ps,
  output logic              running,
  output logic [CNT_W-1:0]  mod_act,
  output logic [CNT_W-1:0]  start_act,
  output logic              cnt_load,
  output logic              irq,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned NBUF = 2;

  reg_sel_e sel;
  logic     ctrl_wr;
  logic     ctrl_rd;

  logic [PS_W-1:0]     ps_q, ps_d;
  logic [CLKSEL_W-1:0] clksel_q, clksel_d;
  logic                ie_q, ie_d;
  logic                of_q, of_d;
  logic                arm_q, arm_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic [DATA_W-1:0]   rd_mux;
  logic [CTRL_W-1:0]   ctrl_view;

  logic [NBUF-1:0]  buf_wr;
  logic [CNT_W-1:0] buf_val [NBUF];
  logic [CNT_W-1:0] act_val [NBUF];

  logic unused_bus_bits;
  assign unused_bus_bits = ^{addr[1:0], wdata[DATA_W-1:CNT_W], wdata[5]};

  assign sel       = reg_sel_e'(addr[3:2]);
  assign ctrl_wr   = wr_en && (sel == SEL_CTRL);
  assign ctrl_rd   = rd_en && (sel == SEL_CTRL);
  assign cnt_load  = wr_en && (sel == SEL_COUNT);
  assign buf_wr[0] = wr_en && (sel == SEL_MODULO);
  assign buf_wr[1] = wr_en && (sel == SEL_START);
  assign running   = (clksel_q == CLKSEL_RUN);

  for (genvar g = 0; g < NBUF; g++) begin : g_dbuf
    mt_dbuf #(
      .W       (CNT_W),
      .RST_VAL ((g == 0) ? {CNT_W{1'b1}} : {CNT_W{1'b0}})
    ) u_dbuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (buf_wr[g]),
      .wdata  (wdata[CNT_W-1:0]),
      .commit (!running),
      .buf_q  (buf_val[g]),
      .act_q  (act_val[g])
    );
  end

  assign mod_act   = act_val[0];
  assign start_act = act_val[1];

  always_comb begin
    ps_d     = ps_q;
    clksel_d = clksel_q;
    ie_d     = ie_q;
    if (ctrl_wr) begin
      ps_d     = wdata[PS_LSB +: PS_W];
      clksel_d = wdata[CLKSEL_LSB +: CLKSEL_W];
      ie_d     = wdata[IE_BIT];
    end

    of_d = of_q;
    if (ovf)                                      of_d = 1'b1;
    else if (ctrl_wr && arm_q && !wdata[OF_BIT])  of_d = 1'b0;

    arm_d = arm_q;
    if (ctrl_wr)              arm_d = 1'b0;
    else if (ctrl_rd && of_q) arm_d = 1'b1;

    ctrl_view = '0;
    ctrl_view[PS_LSB +: PS_W]         = ps_q;
    ctrl_view[CLKSEL_LSB +: CLKSEL_W] = clksel_q;
    ctrl_view[IE_BIT]                 = ie_q;
    ctrl_view[OF_BIT]                 = of_q;

    unique case (sel)
      SEL_CTRL:   rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl_view};
      SEL_COUNT:  rd_mux = {{(DATA_W-CNT_W){1'b0}}, cnt};
      SEL_MODULO: rd_mux = {{(DATA_W-CNT_W){1'b0}}, buf_val[0]};
      default:    rd_mux = {{(DATA_W-CNT_W){1'b0}}, buf_val[1]};
    endcase

    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q     <= '0;
      clksel_q <= '0;
      ie_q     <= 1'b0;
      of_q     <= 1'b0;
      arm_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      ps_q     <= ps_d;
      clksel_q <= clksel_d;
      ie_q     <= ie_d;
      of_q     <= of_d;
      arm_q    <= arm_d;
      rdata_q  <= rdata_d;
    end
  end

  assign ps    = ps_q;
  assign irq   = of_q & ie_q;
  assign rdata = rdata_q;

  // R5: the flag rises only after a counter overflow
  p_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(of_q) |-> $past(ovf));

  // R5: an overflow always leaves the flag set
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> of_q);

  // R8: the flag falls only on an armed control write of zero
  p_clear_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(of_q) |-> $past(ctrl_wr && arm_q && !wdata[OF_BIT]));

  // R10: read data changes only after a read strobe
  p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));

endmodule

// File: rtl/mod_timer.sv
module mod_timer
  import mod_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [PS_W-1:0]  ps;
  logic             running;
  logic             tick;
  logic             cnt_load;
  logic             ovf;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mod_act;
  logic [CNT_W-1:0] start_act;

  mt_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .cnt       (cnt),
    .ovf       (ovf),
    .ps        (ps),
    .running   (running),
    .mod_act   (mod_act),
    .start_act (start_act),
    .cnt_load  (cnt_load),
    .irq       (irq),
    .rdata     (rdata)
  );

  mt_prescaler u_presc (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .run   (running),
    .ps    (ps),
    .tick  (tick)
  );

  mt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .tick      (tick),
    .load      (cnt_load),
    .mod_val   (mod_act),
    .start_val (start_act),
    .cnt_q     (cnt),
    .ovf       (ovf)
  );

  // R2: nothing counts while the clock select is not the running code
  p_stopped_no_ovf_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !running |-> !ovf);

  // R9: interrupt is never raised without the flag visible in the control view
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (rd_en && addr[3:2] == 2'd0 && irq) |=> (rdata[7] && rdata[6]));

endmodule

// File: tb/mod_timer_tb.sv
module mod_timer_tb;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NVEC   = 9;

  localparam logic [3:0] A_CTRL  = 4'h0;
  localparam logic [3:0] A_COUNT = 4'h4;
  localparam logic [3:0] A_MOD   = 4'h8;
  localparam logic [3:0] A_START = 4'hC;

  // {prescaler, start, terminal, edges run, expected count, expected flag}
  localparam logic [71:0] VEC [NVEC] = '{
    {4'd0, 16'h0000, 16'h0009, 16'd5,   16'h0005, 4'd0},
    {4'd0, 16'h0000, 16'h0009, 16'd10,  16'h0000, 4'd1},
    {4'd2, 16'h0010, 16'h0013, 16'd21,  16'h0011, 4'd1},
    {4'd1, 16'h0005, 16'h0005, 16'd7,   16'h0005, 4'd1},
    {4'd3, 16'hFFF0, 16'hFFFF, 16'd200, 16'hFFF9, 4'd1},
    {4'd7, 16'h0000, 16'hFFFF, 16'd300, 16'h0002, 4'd0},
    {4'd0, 16'h0003, 16'h0004, 16'd4,   16'h0003, 4'd1},
    {4'd2, 16'h0000, 16'hFFFF, 16'd3,   16'h0000, 4'd0},
    {4'd2, 16'h0000, 16'hFFFF, 16'd4,   16'h0001, 4'd0}
  };

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic              rd_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int n_checks;
  int n_fail;
  bit done;

  mod_timer u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    n_checks = 0;
    n_fail   = 0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset values
    check("R1 irq", {31'b0, irq}, 32'h0);
    bus_rd(A_CTRL, rd);  check("R1 ctrl", rd, 32'h0);
    bus_rd(A_COUNT, rd); check("R1 count", rd, 32'h0);
    bus_rd(A_MOD, rd);   check("R1 terminal", rd, 32'h0000FFFF);
    bus_rd(A_START, rd); check("R1 start", rd, 32'h0);

    // vector table: R3 R4 R5 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0]  p;
      logic [15:0] s, m, dly, ec;
      logic        ef;
      {p, s, m, dly, ec} = VEC[v][71:4];
      ef = VEC[v][0];
      bus_wr(A_CTRL, 32'h0);
      bus_rd(A_CTRL, rd);
      bus_wr(A_CTRL, 32'h0);
      bus_wr(A_START, {16'h0, s});
      bus_wr(A_MOD, {16'h0, m});
      bus_wr(A_COUNT, 32'hDEAD);
      bus_wr(A_CTRL, 32'h48 | {28'h0, p});
      idle(int'(dly) - 1);
      bus_wr(A_CTRL, 32'h40);
      bus_rd(A_COUNT, rd);
      check($sformatf("R3 R4 count vec%0d", v), rd, {16'h0, ec});
      bus_rd(A_CTRL, rd);
      check($sformatf("R5 flag vec%0d", v), {31'b0, rd[7]}, {31'b0, ef});
      check($sformatf("R9 irq vec%0d", v), {31'b0, irq}, {31'b0, ef});
    end

    // R7 terminal written mid-run stays in holding copy
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_CTRL, rd);
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_START, 32'h0);
    bus_wr(A_MOD, 32'hFFFF);
    bus_wr(A_COUNT, 32'h0);
    bus_wr(A_CTRL, 32'h08);
    idle(4);
    bus_wr(A_MOD, 32'h3);
    idle(14);
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_COUNT, rd); check("R7 running copy held", rd, 32'd20);
    bus_rd(A_CTRL, rd);  check("R7 no overflow", {31'b0, rd[7]}, 32'h0);
    bus_rd(A_MOD, rd);   check("R7 holding readback", rd, 32'h3);
    bus_wr(A_COUNT, 32'h0);
    bus_wr(A_CTRL, 32'h08);
    idle(4);
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_COUNT, rd); check("R7 committed terminal", rd, 32'h1);

    // R9 gating, R8 acknowledge rules
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    bus_wr(A_CTRL, 32'h40);
    check("R9 irq enabled", {31'b0, irq}, 32'h1);
    bus_rd(A_CTRL, rd);  check("R8 unarmed clear ignored", rd, 32'hC0);
    bus_wr(A_CTRL, 32'hC0);
    bus_rd(A_CTRL, rd);  check("R8 write one no effect", rd, 32'hC0);
    bus_wr(A_CTRL, 32'h40);
    bus_rd(A_CTRL, rd);  check("R8 armed clear", rd, 32'h40);
    check("R9 irq after clear", {31'b0, irq}, 32'h0);

    // R2 clock-select code 2 holds the count
    bus_wr(A_CTRL, 32'h10);
    idle(10);
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_COUNT, rd); check("R2 select 2 holds", rd, 32'h1);
    idle(10);
    bus_rd(A_COUNT, rd); check("R2 select 0 holds", rd, 32'h1);

    // R6 count write loads the start value
    bus_wr(A_START, 32'h7);
    bus_wr(A_COUNT, 32'h1234);
    bus_rd(A_COUNT, rd); check("R6 load start", rd, 32'h7);

    // R10 control layout, bit 5 reads zero
    bus_wr(A_CTRL, 32'h7D);
    bus_rd(A_CTRL, rd);  check("R10 ctrl layout", rd, 32'h5D);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule